// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds an Ethernet transmit path from a ring of buffer descriptors held in system memory. Software lays out eight-byte descriptors, points the block at the first one through a ring-base register, sets the enable bit in the control register and writes the activate register. The block then works through the ring on its own. It fetches each descriptor over a single-word memory master port and streams the bytes of that descriptor's buffer out on a byte-wide valid/ready port. It then hands the descriptor back to software by clearing its ready flag in memory. Finally it moves to the next descriptor, or returns to the ring base when the descriptor asks for a wrap.

A frame may be spread over several descriptors. The descriptor carrying the last flag closes the frame, and the byte port marks the final byte with a last marker. The bytes of one frame are capped at a fixed limit: a descriptor that would push the frame past that limit is copied only in part and raises a babble event. Each handled descriptor produces a buffer-done pulse, and each closed frame also produces a frame-done pulse. A walk ends at the first descriptor software has not marked ready, or after a fixed number of descriptors. An activate request that arrives during a walk is held and starts one more walk afterwards.

Top module: `txring_walker`

## Requirements
- R1: After reset, mem_req, tx_valid, ev_buf, ev_frame and ev_babble are all low.
- R2: A register write to offset 0x014 starts a walk only while bit 1 of the control register (offset 0x024) is 1. With that bit at 0, the write causes no memory request.
- R3: A descriptor at address D holds flags in bits 31:16 and the byte length in bits 15:0 of the word at D, and the buffer address in the word at D+4. Flag bit 15 is ready, bit 13 is wrap and bit 11 is last. A walk reads the word at D and stops, with no further access, when bit 15 is 0.
- R4: Buffer bytes leave in increasing address order from any start alignment. The byte at address A is bits 31-8*(A mod 4) down to 24-8*(A mod 4) of the word at A rounded down to a multiple of 4. Each word is fetched once per descriptor, and a zero-length buffer fetches nothing.
- R5: tx_last is 1 exactly on the final byte of a descriptor that has the last flag and copies at least one byte. Frames may span any number of descriptors.
- R6: After its bytes are sent, each descriptor's first word is written back to D with bit 31 cleared. All other flag bits and the length field are written back unchanged.
- R7: After write-back, the next descriptor address is the ring base if the wrap flag is set, and D+8 otherwise.
- R8: A write to offset 0x184 sets the ring base to the written value with bits 1:0 cleared, and also loads the next descriptor address with that value.
- R9: Within one walk, the bytes of one frame are capped at MAX_FRAME (2032). A descriptor whose length exceeds the room left copies only that room, possibly zero bytes, and raises ev_babble. The frame count restarts at 0 after a last-flag descriptor and at each walk start.
- R10: ev_buf pulses for exactly one cycle, in the cycle after each write-back is accepted. ev_frame and ev_babble pulse together with it when that descriptor had the last flag or was cut.
- R11: A walk ends after MAX_DESC descriptors have been handled, without reading the next one.
- R12: Activate requests that arrive while a walk is running cause exactly one further walk, however many arrive.
- R13: tx_data and tx_last hold steady while tx_valid is high and tx_ready is low. A memory request holds all its fields until mem_ack. No memory request is made while a byte waits on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Consumer accepts the byte |
| ev_buf | output | 1 | One-cycle pulse per descriptor handled |
| ev_frame | output | 1 | One-cycle pulse when a frame is closed |
| ev_babble | output | 1 | One-cycle pulse when a descriptor was cut to the frame limit |

## Verification
Most internal state leaves a trace on the memory port within a few cycles. A wrong descriptor pointer shows up at the next header fetch. A stale flags or length register shows up in the write-back word. A wrong byte address shows up in the next buffer word fetch. The bench compares every memory access, every accepted byte and every event pulse against a behavioural walk of its own memory image, so any of these faults becomes visible on the first wrong access. A wrong frame count only shows when the limit is reached, so one test builds a frame that crosses the limit and follows it with a short frame. A lost or duplicated pending request shows as a missing or extra header read at the end of a walk.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // register byte offsets decoded by this block
    localparam logic [9:0] OFS_ACTIVATE = 10'h014;
    localparam logic [9:0] OFS_CONTROL  = 10'h024;
    localparam logic [9:0] OFS_RING     = 10'h184;
    localparam int unsigned CTRL_EN_BIT = 1;

    // descriptor flag positions inside the 16-bit flags half-word
    localparam int unsigned FLG_READY = 15;
    localparam int unsigned FLG_WRAP  = 13;
    localparam int unsigned FLG_LAST  = 11;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam logic [31:0] DESC_STRIDE = 32'd8;
    localparam logic [31:0] PTR_OFFSET  = 32'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_FILL,
        ST_EMIT,
        ST_BACK
    } walk_st_e;

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [9:0]  addr,
    input  logic [31:0] wdata,
    output logic        start,
    output logic        base_load,
    output logic [31:0] base_new,
    output logic [31:0] base
);

    typedef struct packed {
        logic        en;
        logic [31:0] base;
    } regs_t;

    regs_t q, n;

    logic unused_bit0;
    assign unused_bit0 = wdata[0];

    always_comb begin
        n = q;
        if (wr && addr == OFS_CONTROL) begin
            n.en = wdata[CTRL_EN_BIT];
        end
        if (wr && addr == OFS_RING) begin
            n.base = {wdata[31:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign start     = wr && (addr == OFS_ACTIVATE) && q.en;
    assign base_load = wr && (addr == OFS_RING);
    assign base_new  = {wdata[31:2], 2'b00};
    assign base      = q.base;

endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick #(
    parameter int unsigned DW = 32,
    localparam int unsigned LANES = DW / 8,
    localparam int unsigned SEL_W = $clog2(LANES)
) (
    input  logic [DW-1:0]    word,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       pick
);

    // lane 0 is the most significant byte: lowest address first
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign lane[g] = word[DW-1-8*g -: 8];
    end

    assign pick = lane[sel];

endmodule

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned LEN_W     = 16,
    localparam int unsigned ACC_W    = $clog2(MAX_FRAME + 1)
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] eff,
    output logic             cut
);

    logic [LEN_W-1:0] room;

    always_comb begin
        room = LEN_W'(MAX_FRAME) - LEN_W'(acc);
        cut  = len > room;
        eff  = cut ? room : len;
    end

endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txr_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned MAX_DESC  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [9:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_buf,
    output logic        ev_frame,
    output logic        ev_babble
);

    localparam int unsigned ACC_W = $clog2(MAX_FRAME + 1);
    localparam int unsigned CNT_W = $clog2(MAX_DESC + 1);
    localparam int unsigned SEL_W = $clog2(WORD_W / 8);

    typedef struct packed {
        walk_st_e          st;
        logic [31:0]       ptr;
        logic [HALF_W-1:0] flags;
        logic [HALF_W-1:0] len;
        logic [31:0]       baddr;
        logic [HALF_W-1:0] remain;
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              cut;
        logic [31:0]       word;
        logic              pend;
        logic              ev_b;
        logic              ev_f;
        logic              ev_x;
    } walk_t;

    walk_t q, n;

    logic        start;
    logic        base_load;
    logic [31:0] base_new;
    logic [31:0] base;
    logic [HALF_W-1:0] clip_eff;
    logic              clip_cut;
    logic [7:0]        cur_byte;
    logic              finish;

    txr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .start     (start),
        .base_load (base_load),
        .base_new  (base_new),
        .base      (base)
    );

    txr_len_clip #(
        .MAX_FRAME (MAX_FRAME),
        .LEN_W     (HALF_W)
    ) u_clip (
        .acc (q.acc),
        .len (q.len),
        .eff (clip_eff),
        .cut (clip_cut)
    );

    txr_byte_pick #(
        .DW (WORD_W)
    ) u_pick (
        .word (q.word),
        .sel  (q.baddr[SEL_W-1:0]),
        .pick (cur_byte)
    );

    always_comb begin
        n      = q;
        n.ev_b = 1'b0;
        n.ev_f = 1'b0;
        n.ev_x = 1'b0;
        finish = 1'b0;

        if (start && q.st != ST_IDLE) begin
            n.pend = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.st  = ST_HDR;
                    n.cnt = '0;
                    n.acc = '0;
                end
            end
            ST_HDR: begin
                if (mem_ack) begin
                    n.flags = mem_rdata[31:16];
                    n.len   = mem_rdata[15:0];
                    if (!mem_rdata[16 + FLG_READY]) begin
                        finish = 1'b1;
                    end else begin
                        n.st = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                if (mem_ack) begin
                    n.baddr  = mem_rdata;
                    n.remain = clip_eff;
                    n.cut    = clip_cut;
                    n.acc    = q.acc + clip_eff[ACC_W-1:0];
                    n.st     = (clip_eff == '0) ? ST_BACK : ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    n.word = mem_rdata;
                    n.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (tx_ready) begin
                    n.baddr  = q.baddr + 32'd1;
                    n.remain = q.remain - HALF_W'(1);
                    if (q.remain == HALF_W'(1)) begin
                        n.st = ST_BACK;
                    end else if (q.baddr[SEL_W-1:0] == '1) begin
                        n.st = ST_FILL;
                    end
                end
            end
            ST_BACK: begin
                if (mem_ack) begin
                    n.ev_b = 1'b1;
                    n.ev_f = q.flags[FLG_LAST];
                    n.ev_x = q.cut;
                    if (q.flags[FLG_LAST]) begin
                        n.acc = '0;
                    end
                    n.ptr = q.flags[FLG_WRAP] ? base : (q.ptr + DESC_STRIDE);
                    n.cnt = q.cnt + CNT_W'(1);
                    if ((q.cnt + CNT_W'(1)) == CNT_W'(MAX_DESC)) begin
                        finish = 1'b1;
                    end else begin
                        n.st = ST_HDR;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        if (finish) begin
            n.pend = 1'b0;
            if (q.pend || start) begin
                n.st  = ST_HDR;
                n.cnt = '0;
                n.acc = '0;
            end else begin
                n.st = ST_IDLE;
            end
        end

        if (base_load) begin
            n.ptr = base_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr;
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + PTR_OFFSET;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.baddr[31:SEL_W], SEL_W'(0)};
            end
            ST_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ptr;
                mem_wdata = {q.flags & ~(HALF_W'(1) << FLG_READY), q.len};
            end
            default: ;
        endcase
    end

    assign tx_valid  = (q.st == ST_EMIT);
    assign tx_data   = cur_byte;
    assign tx_last   = (q.st == ST_EMIT) && (q.remain == HALF_W'(1)) && q.flags[FLG_LAST];
    assign ev_buf    = q.ev_b;
    assign ev_frame  = q.ev_f;
    assign ev_babble = q.ev_x;

endmodule

// File: rtl/txr_walker_chk.sv
module txr_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        tx_ready,
    input logic        ev_buf,
    input logic        ev_frame,
    input logic        ev_babble
);

    p_tx_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_pause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    p_wb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    p_frame_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |-> ev_buf);

    p_babble_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_babble |-> ev_buf);

    p_buf_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf |=> !ev_buf);

endmodule

bind txring_walker txr_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .ev_buf    (ev_buf),
    .ev_frame  (ev_frame),
    .ev_babble (ev_babble)
);

// File: tb/sim_txring_walker.sv
`timescale 1ns/1ps
module sim_txring_walker;

    localparam int LIM  = 6;
    localparam int MAXF = 2032;
    localparam logic [9:0] A_ACT  = 10'h014;
    localparam logic [9:0] A_CTRL = 10'h024;
    localparam logic [9:0] A_RING = 10'h184;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } bus_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        ev_buf, ev_frame, ev_babble;

    always #2.5 clk = ~clk;

    txring_walker #(.MAX_FRAME(MAXF), .MAX_DESC(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble)
    );

    logic [31:0] mem [0:4095];
    logic [31:0] rm  [0:4095];
    bus_t        bq [$];
    logic [8:0]  bytq [$];
    logic [1:0]  evq [$];
    int checks = 0;
    int errors = 0;
    int evcount = 0;
    int stall_mode = 0;
    logic [31:0] mbase = '0, mptr = '0;
    logic        men = 1'b0;
    logic        prev_wr_ack = 1'b0;
    logic        pv_valid = 1'b0, pv_ready = 1'b0;
    logic [8:0]  pv_byte = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        mem[a[13:2]] = v;
        rm[a[13:2]]  = v;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] b);
        logic [31:0] a4;
        a4 = a + 32'd4;
        put_word(a, {fl, ln});
        put_word(a4, b);
    endtask

    // behavioural walk over the bench's own image of memory
    task automatic model_walk();
        int cnt = 0;
        int acc = 0;
        while (cnt < LIM) begin
            logic [31:0] w0, w1, wb, a4, ba, wd;
            logic [15:0] fl, ln;
            int room, eff;
            bit cut;
            bus_t t;
            w0 = rm[mptr[13:2]];
            t = {1'b0, mptr, 32'h0}; bq.push_back(t);
            if (!w0[31]) break;
            a4 = mptr + 32'd4;
            w1 = rm[a4[13:2]];
            t = {1'b0, a4, 32'h0}; bq.push_back(t);
            fl = w0[31:16]; ln = w0[15:0];
            room = MAXF - acc;
            cut = int'(ln) > room;
            eff = cut ? room : int'(ln);
            for (int i = 0; i < eff; i++) begin
                ba = w1 + 32'(i);
                if (i == 0 || ba[1:0] == 2'b00) begin
                    t = {1'b0, ba[31:2], 2'b00, 32'h0}; bq.push_back(t);
                end
                wd = rm[ba[13:2]] >> (24 - 8 * int'(ba[1:0]));
                bytq.push_back({fl[11] && (i == eff - 1), wd[7:0]});
            end
            acc += eff;
            if (fl[11]) acc = 0;
            wb = {fl & 16'h7FFF, ln};
            rm[mptr[13:2]] = wb;
            t = {1'b1, mptr, wb}; bq.push_back(t);
            evq.push_back({fl[11], cut});
            mptr = fl[13] ? mbase : (mptr + 32'd8);
            cnt++;
        end
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == A_RING) begin
            mbase = {v[31:2], 2'b00};
            mptr  = mbase;
        end
        if (a == A_CTRL) men = v[1];
    endtask

    task automatic start_walk();
        reg_write(A_ACT, 32'h0);
        if (men) model_walk();
    endtask

    task automatic wait_done(input string tag);
        do @(negedge clk); while (bq.size() != 0 || bytq.size() != 0 || evq.size() != 0);
        repeat (8) @(negedge clk);
        chk(!mem_req && !tx_valid, tag, {30'h0, mem_req, tx_valid}, 32'h0);
    endtask

    // per-cycle comparison against the reference streams
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            tx_ready = 1'b0;
            prev_wr_ack = 1'b0;
        end else begin
            chk(ev_buf == prev_wr_ack, "R10 ev_buf one cycle after write-back", 32'(ev_buf), 32'(prev_wr_ack));
            if (ev_buf) begin
                evcount++;
                if (evq.size() == 0) chk(1'b0, "R10 unexpected event", 32'(ev_buf), 32'h0);
                else begin
                    logic [1:0] e;
                    e = evq.pop_front();
                    chk({ev_frame, ev_babble} == e, "R5 R9 event flags frame/babble", 32'({ev_frame, ev_babble}), 32'(e));
                end
            end
            if (pv_valid && !pv_ready)
                chk(tx_valid && {tx_last, tx_data} == pv_byte, "R13 byte held under stall", 32'({tx_valid, tx_last, tx_data}), 32'({1'b1, pv_byte}));
            tx_ready = (stall_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
            if (tx_valid && tx_ready) begin
                if (bytq.size() == 0) chk(1'b0, "R4 unexpected byte", 32'({tx_last, tx_data}), 32'h0);
                else begin
                    logic [8:0] eb;
                    eb = bytq.pop_front();
                    chk({tx_last, tx_data} == eb, "R4 R5 byte value/last", 32'({tx_last, tx_data}), 32'(eb));
                end
            end
            pv_valid = tx_valid; pv_ready = tx_ready; pv_byte = {tx_last, tx_data};
            prev_wr_ack = 1'b0;
            mem_ack = 1'b0;
            if (mem_req && (stall_mode == 0 || $urandom_range(0, 3) != 0)) begin
                mem_ack = 1'b1;
                if (bq.size() == 0) chk(1'b0, "R2 R3 unexpected memory access", mem_addr, 32'h0);
                else begin
                    bus_t e;
                    e = bq.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr, "R3 R7 R8 access address/kind", {mem_addr[31:1], mem_we}, {e.addr[31:1], e.we});
                    if (e.we) chk(mem_wdata == e.data, "R6 write-back word", mem_wdata, e.data);
                end
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    prev_wr_ack = 1'b1;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", bq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 32'(i) * 32'h9E3779B9 ^ 32'h0F1E2D3C;
            rm[i]  = mem[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !tx_valid && !ev_buf && !ev_frame && !ev_babble, "R1 reset outputs",
            {27'h0, mem_req, tx_valid, ev_buf, ev_frame, ev_babble}, 32'h0);

        // R8: low bits of the ring base are dropped
        reg_write(A_RING, 32'h0000_0103);
        // R2: activate while disabled
        put_desc(32'h100, 16'h8000, 16'd5, 32'h801);
        put_desc(32'h108, 16'h8800, 16'd3, 32'h902);
        put_desc(32'h110, 16'h0000, 16'd0, 32'h0);
        reg_write(A_ACT, 32'h0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!mem_req, "R2 no access while disabled", 32'(mem_req), 32'h0);
        end

        // R3 R4 R5 R6 R7: two-descriptor frame, unaligned buffers
        reg_write(A_CTRL, 32'h2);
        start_walk();
        wait_done("R3 walk stops at not-ready descriptor");

        // R7: wrap back to the ring base, buffer crossing a word
        put_desc(32'h110, 16'hA800, 16'd2, 32'hA03);
        start_walk();
        wait_done("R7 wrap then stop at base");

        // R9: frame capped at the limit, zero-byte cut descriptor, then a fresh frame
        stall_mode = 1;
        reg_write(A_RING, 32'h0000_0142);
        put_desc(32'h140, 16'h8000, 16'd1500, 32'h1000);
        put_desc(32'h148, 16'h8000, 16'd1000, 32'h1000);
        put_desc(32'h150, 16'h8800, 16'd10,   32'h1000);
        put_desc(32'h158, 16'h8800, 16'd4,    32'h2001);
        put_desc(32'h160, 16'h0000, 16'd0,    32'h0);
        start_walk();
        wait_done("R9 capped frame walk completes");

        // R11 R12: run limit, three activates collapse into one extra walk
        reg_write(A_RING, 32'h0000_0180);
        for (int i = 0; i < 8; i++)
            put_desc(32'h180 + 32'(8 * i), (i % 2 == 1) ? 16'h8800 : 16'h8000, 16'd3, 32'h3000 + 32'(16 * i));
        put_desc(32'h1C0, 16'h0000, 16'd0, 32'h0);
        evcount = 0;
        start_walk();
        reg_write(A_ACT, 32'h0);
        reg_write(A_ACT, 32'h0);
        model_walk();
        wait_done("R12 pending walk completes");
        chk(evcount == 8, "R11 R12 descriptors handled over two walks", 32'(evcount), 32'd8);

        // R2: disable again, a ready descriptor stays untouched
        stall_mode = 0;
        reg_write(A_CTRL, 32'h0);
        put_desc(32'h1C0, 16'h8800, 16'd2, 32'h3100);
        reg_write(A_ACT, 32'h0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(!mem_req, "R2 disabled activate ignored", 32'(mem_req), 32'h0);
        end
        chk(mem[32'h1C0 >> 2][31], "R2 descriptor still ready", mem[32'h1C0 >> 2], {16'h8800, 16'd2});
        chk(bq.size() == 0 && bytq.size() == 0 && evq.size() == 0, "R5 all expected traffic seen",
            32'(bq.size() + bytq.size() + evq.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule